// File: doc/BRIEF.md
# Programmable Address-Window Chip-Select with Wait-State Timer

This block is one chip-select channel for a processor bus with a 20-bit address. Software programs a 16-bit start register that holds a 10-bit base field and a 4-bit wait count. When a bus cycle starts, the block compares the base against a slice of the address. It compares the upper ten bits for memory cycles and a middle ten-bit slice for I/O cycles. It drives an active-low select for the whole cycle when the slice is at or above the base.

For a selected cycle, the block holds off the end of the cycle for at least the programmed number of wait clocks. The external ready input can stretch the cycle further. An unselected cycle gets no inserted waits.

The base, the wait count and the select decision are taken when the cycle starts. A register write never disturbs a cycle that is already running.

Top module: `cs_channel`

## Requirements
- R1: After reset the register reads back 16'hFFCF (base 10'h3FF in bits 15:6, wait count 4'hF in bits 3:0), `cs_n` is 1 and `cyc_done` is 0.
- R2: A write with `cfg_wr_en` stores bits 15:6 as the base and bits 3:0 as the wait count. Bits 5:4 are discarded and always read back as 0, so `cfg_rd_data` equals the written value ANDed with 16'hFFCF.
- R3: For a memory cycle (`cyc_io` = 0), the cycle is selected exactly when `addr[19:10]` is greater than or equal to the base.
- R4: For an I/O cycle (`cyc_io` = 1), the cycle is selected exactly when `addr[15:6]` is greater than or equal to the base.
- R5: `cs_n` is 1 whenever no cycle is in progress. During a cycle it holds one value from the first cycle clock through the clock where `cyc_done` is 1. That value is 0 if the cycle is selected and 1 if it is not.
- R6: A `cyc_start` sampled high on a rising edge while idle begins a cycle. The clock after that edge is cycle clock 0. With a wait count of 0 and `rdy` high, `cyc_done` is 1 in cycle clock 0.
- R7: With a wait count N and `rdy` high, a selected cycle asserts `cyc_done` first in cycle clock N.
- R8: `cyc_done` is 1 only when the inserted waits are used up and `rdy` is 1 in the same clock. A selected cycle with `rdy` low for its first L clocks ends in clock max(N, L).
- R9: An unselected cycle inserts no waits: with `rdy` low for its first L clocks, it ends in clock L.
- R10: A register write, including one on the same edge as `cyc_start`, does not change the select or the wait count of the cycle that edge starts or that is already running. The next cycle uses the new value.
- R11: A `cyc_start` seen while a cycle is in progress is ignored. The running cycle keeps its select and length, and no second cycle follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Start register write strobe |
| cfg_wr_data | input | 16 | Start register write value |
| cfg_rd_data | output | 16 | Start register read value, bits 5:4 zero |
| cyc_start | input | 1 | Bus cycle start request, sampled on the rising edge |
| cyc_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle, sampled with `cyc_start` |
| addr | input | 20 | Bus address, sampled with `cyc_start` |
| rdy | input | 1 | External ready, active high |
| cs_n | output | 1 | Active-low chip select |
| cyc_done | output | 1 | The current bus cycle ends this clock |

## Verification
Two functions can fall in the same clock: a register write and the start of a bus cycle. The bench drives both on the same edge. The register holds a small base with two waits, and the write moves it to the top base with no waits. The cycle that edge starts must still be selected and must last two wait clocks. A second cycle at the same address must then be unselected and end at once. A write issued mid-cycle is judged the same way.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;

  typedef enum logic {
    CYC_MEM = 1'b0,
    CYC_IO  = 1'b1
  } cyc_kind_e;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_ACTIVE = 1'b1
  } phase_e;

endpackage

// File: rtl/cs_rst_sync.sv
`timescale 1ns/1ps
module cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/cs_start_reg.sv
`timescale 1ns/1ps
module cs_start_reg #(
  parameter int REG_W  = 16,
  parameter int BASE_W = 10,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [BASE_W-1:0] base_o,
  output logic [WS_W-1:0]   ws_o,
  output logic [REG_W-1:0]  rd_data
);

  localparam int BASE_LSB = REG_W - BASE_W;
  localparam int RSV_W    = BASE_LSB - WS_W;

  logic [BASE_W-1:0] base_q, base_d;
  logic [WS_W-1:0]   ws_q, ws_d;

  always_comb begin
    base_d = wr_data[REG_W-1:BASE_LSB];
    ws_d   = wr_data[WS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '1;
      ws_q   <= '1;
    end else if (wr_en) begin
      base_q <= base_d;
      ws_q   <= ws_d;
    end
  end

  assign base_o  = base_q;
  assign ws_o    = ws_q;
  assign rd_data = {base_q, {RSV_W{1'b0}}, ws_q};

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q == $past(wr_data[REG_W-1:BASE_LSB])) && (ws_q == $past(wr_data[WS_W-1:0]))); // R2

  AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q) && $stable(ws_q)); // R2

endmodule

// File: rtl/cs_addr_cmp.sv
`timescale 1ns/1ps
module cs_addr_cmp #(
  parameter int ADDR_W = 20,
  parameter int BASE_W = 10,
  parameter int MEM_LSB = 10,
  parameter int IO_LSB  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_io,
  input  logic [BASE_W-1:0] base,
  output logic              hit
);

  localparam int MEM_MSB = MEM_LSB + BASE_W - 1;
  localparam int IO_MSB  = IO_LSB + BASE_W - 1;

  logic [BASE_W-1:0] mem_slice;
  logic [BASE_W-1:0] io_slice;
  logic [BASE_W-1:0] pick;

  generate
    if (MEM_MSB < ADDR_W) begin : g_mem_fit
      assign mem_slice = addr[MEM_MSB:MEM_LSB];
    end else begin : g_mem_top
      assign mem_slice = addr[ADDR_W-1:ADDR_W-BASE_W];
    end
    if (IO_MSB < ADDR_W) begin : g_io_fit
      assign io_slice = addr[IO_MSB:IO_LSB];
    end else begin : g_io_top
      assign io_slice = addr[ADDR_W-1:ADDR_W-BASE_W];
    end
  endgenerate

  always_comb begin
    pick = is_io ? io_slice : mem_slice;
    hit  = (pick >= base);
  end

endmodule

// File: rtl/cs_wait_ctr.sv
`timescale 1ns/1ps
module cs_wait_ctr
  import cs_pkg::*;
#(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            sel_in,
  input  logic [WS_W-1:0] load_val,
  input  logic            rdy,
  output logic            busy,
  output logic            sel_o,
  output logic            done
);

  phase_e          ph_q, ph_d;
  logic [WS_W-1:0] cnt_q, cnt_d;
  logic            sel_q, sel_d;
  logic            accept, cnt_zero, ph_en, cnt_en, sel_en;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    accept   = start_req && (ph_q == PH_IDLE);
    done     = (ph_q == PH_ACTIVE) && cnt_zero && rdy;

    ph_d  = ph_q;
    cnt_d = cnt_q;
    sel_d = sel_q;
    if (accept) begin
      ph_d  = PH_ACTIVE;
      sel_d = sel_in;
      cnt_d = sel_in ? load_val : '0;
    end else if (ph_q == PH_ACTIVE) begin
      if (!cnt_zero) begin
        cnt_d = cnt_q - 1'b1;
      end else if (rdy) begin
        ph_d = PH_IDLE;
      end
    end

    ph_en  = accept || done;
    cnt_en = accept || ((ph_q == PH_ACTIVE) && !cnt_zero);
    sel_en = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign busy  = (ph_q == PH_ACTIVE);
  assign sel_o = sel_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_zero) |=> busy && (cnt_q == $past(cnt_q) - 1'b1)); // R7

  AST_WAIT_FOR_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_zero && !rdy) |=> busy); // R8

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R11

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> $stable(sel_q)); // R11

  AST_UNSEL_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sel_in) |=> cnt_zero); // R9

endmodule

// File: rtl/cs_channel.sv
`timescale 1ns/1ps
module cs_channel #(
  parameter int ADDR_W  = 20,
  parameter int REG_W   = 16,
  parameter int BASE_W  = 10,
  parameter int WS_W    = 4,
  parameter int MEM_LSB = 10,
  parameter int IO_LSB  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              cyc_start,
  input  logic              cyc_io,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdy,
  output logic              cs_n,
  output logic              cyc_done
);

  logic              srst_n;
  logic [BASE_W-1:0] base;
  logic [WS_W-1:0]   ws;
  logic              hit;
  logic              busy;
  logic              sel;

  cs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cs_start_reg #(.REG_W(REG_W), .BASE_W(BASE_W), .WS_W(WS_W)) u_reg (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .base_o  (base),
    .ws_o    (ws),
    .rd_data (cfg_rd_data)
  );

  cs_addr_cmp #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .MEM_LSB(MEM_LSB), .IO_LSB(IO_LSB)) u_cmp (
    .addr  (addr),
    .is_io (cyc_io),
    .base  (base),
    .hit   (hit)
  );

  cs_wait_ctr #(.WS_W(WS_W)) u_ctr (
    .clk       (clk),
    .rst_n     (srst_n),
    .start_req (cyc_start),
    .sel_in    (hit),
    .load_val  (ws),
    .rdy       (rdy),
    .busy      (busy),
    .sel_o     (sel),
    .done      (cyc_done)
  );

  assign cs_n = !(busy && sel);

  AST_CS_STABLE: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && !cyc_done) |=> $stable(cs_n)); // R5

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!srst_n)
    !busy |-> cs_n); // R5

  AST_DONE_HAS_RDY: assert property (@(posedge clk) disable iff (!srst_n)
    cyc_done |-> rdy); // R8

endmodule

// File: tb/sim_cs_channel.sv
`timescale 1ns/1ps
module sim_cs_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [15:0] cfg_wr_data;
  logic [15:0] cfg_rd_data;
  logic        cyc_start;
  logic        cyc_io;
  logic [19:0] addr;
  logic        rdy;
  logic        cs_n;
  logic        cyc_done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cs_channel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cyc_start(cyc_start), .cyc_io(cyc_io), .addr(addr),
    .rdy(rdy), .cs_n(cs_n), .cyc_done(cyc_done)
  );

  typedef struct packed {
    logic        io;
    logic [19:0] a;
    logic [15:0] regv;
    logic [7:0]  rlow;
    logic        sel;
    logic [7:0]  lat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 20'h40000, 16'h4002, 8'd0, 1'b1, 8'd2},
    '{1'b0, 20'h3FFFF, 16'h4002, 8'd0, 1'b0, 8'd0},
    '{1'b1, 20'h04000, 16'h4003, 8'd0, 1'b1, 8'd3},
    '{1'b1, 20'hF003F, 16'h4003, 8'd0, 1'b0, 8'd0},
    '{1'b0, 20'h00400, 16'h0040, 8'd3, 1'b1, 8'd3},
    '{1'b0, 20'hFFFFF, 16'h4002, 8'd5, 1'b1, 8'd5},
    '{1'b0, 20'h00000, 16'h000F, 8'd0, 1'b1, 8'd15},
    '{1'b0, 20'h40000, 16'h4035, 8'd0, 1'b1, 8'd5},
    '{1'b0, 20'hFFC00, 16'hFFC1, 8'd0, 1'b1, 8'd1},
    '{1'b0, 20'hFF800, 16'hFFC1, 8'd2, 1'b0, 8'd2},
    '{1'b1, 20'h3FFFF, 16'h4003, 8'd4, 1'b1, 8'd4},
    '{1'b1, 20'h00000, 16'h0000, 8'd1, 1'b1, 8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // Runs one bus cycle; optional write on the start edge or at cycle clock 1,
  // optional start kept high for the first two cycle clocks.
  task automatic run_cyc(input logic io, input logic [19:0] a, input int rlow,
                         input bit wr_at_start, input bit wr_mid, input logic [15:0] wv,
                         input bit hold_start,
                         output logic sel_seen, output bit steady, output int lat,
                         output logic post_csn, output logic post_done);
    int n;
    @(negedge clk);
    cyc_start = 1'b1; cyc_io = io; addr = a; rdy = (rlow == 0);
    if (wr_at_start) begin cfg_wr_en = 1'b1; cfg_wr_data = wv; end
    n = 0; steady = 1'b1; sel_seen = 1'b0; lat = -1;
    forever begin
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (!hold_start || n >= 2) cyc_start = 1'b0;
      if (hold_start && n < 2) begin cyc_io = ~io; addr = ~a; end
      if (wr_mid && n == 1) begin cfg_wr_en = 1'b1; cfg_wr_data = wv; end
      rdy = (n >= rlow);
      #0.5;
      if (n == 0) sel_seen = !cs_n;
      else if ((!cs_n) !== sel_seen) steady = 1'b0;
      if (cyc_done) begin lat = n; break; end
      n++;
      if (n > 60) break;
    end
    @(negedge clk);
    cfg_wr_en = 1'b0; cyc_start = 1'b0;
    #0.5;
    post_csn = cs_n; post_done = cyc_done;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic s, pc, pd;
    bit st;
    int lt;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; cyc_start = 1'b0;
    cyc_io = 1'b0; addr = '0; rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset readback", 32'(cfg_rd_data), 32'hFFCF);
    chk("R1 reset cs_n", 32'(cs_n), 32'h1);
    chk("R1 reset done", 32'(cyc_done), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 readback after release", 32'(cfg_rd_data), 32'hFFCF);

    // Default register: base 3FF, 15 waits
    run_cyc(1'b0, 20'hFFC00, 0, 0, 0, 16'h0, 0, s, st, lt, pc, pd);
    chk("R1 R3 default base select", 32'(s), 32'h1);
    chk("R7 default wait 15", 32'(lt), 32'd15);
    chk("R5 cs_n steady", 32'(st), 32'h1);

    for (int i = 0; i < NV; i++) begin
      wr_reg(VECS[i].regv);
      chk("R2 readback", 32'(cfg_rd_data), 32'(VECS[i].regv & 16'hFFCF));
      run_cyc(VECS[i].io, VECS[i].a, int'(VECS[i].rlow), 0, 0, 16'h0, 0, s, st, lt, pc, pd);
      chk(VECS[i].io ? "R4 io select" : "R3 mem select", 32'(s), 32'(VECS[i].sel));
      chk(VECS[i].sel ? "R6 R7 R8 selected length" : "R9 unselected length", 32'(lt), 32'(VECS[i].lat));
      chk("R5 cs_n steady in cycle", 32'(st), 32'h1);
      chk("R5 cs_n idle after", 32'(pc), 32'h1);
    end

    // Write on the start edge: cycle keeps old base 100 / 2 waits
    wr_reg(16'h4002);
    run_cyc(1'b0, 20'h40000, 0, 1, 0, 16'hFFC0, 0, s, st, lt, pc, pd);
    chk("R10 same-edge write keeps select", 32'(s), 32'h1);
    chk("R10 same-edge write keeps waits", 32'(lt), 32'd2);
    run_cyc(1'b0, 20'h40000, 0, 0, 0, 16'h0, 0, s, st, lt, pc, pd);
    chk("R10 next cycle sees new base", 32'(s), 32'h0);
    chk("R10 next cycle no waits", 32'(lt), 32'd0);

    // Write during a running cycle
    wr_reg(16'h0046);
    run_cyc(1'b1, 20'h00040, 0, 0, 1, 16'hFFC1, 0, s, st, lt, pc, pd);
    chk("R10 mid-cycle write keeps select", 32'(s), 32'h1);
    chk("R10 mid-cycle write keeps waits", 32'(lt), 32'd6);
    chk("R5 cs_n steady across write", 32'(st), 32'h1);
    chk("R2 mid-cycle write landed", 32'(cfg_rd_data), 32'hFFC1);

    // Start held while busy, with a different address and type
    wr_reg(16'h4004);
    run_cyc(1'b0, 20'h40000, 0, 0, 0, 16'h0, 1, s, st, lt, pc, pd);
    chk("R11 busy start ignored select", 32'(s), 32'h1);
    chk("R11 busy start ignored length", 32'(lt), 32'd4);
    chk("R11 cs_n steady", 32'(st), 32'h1);
    chk("R11 no follow-on cycle cs_n", 32'(pc), 32'h1);
    chk("R11 no follow-on cycle done", 32'(pd), 32'h0);

    // Idle with rdy high: no done, no select
    rdy = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    chk("R5 idle cs_n", 32'(cs_n), 32'h1);
    chk("R8 idle no done", 32'(cyc_done), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule